// File: doc/BRIEF.md
# Indirect Channel Configuration RAM Port

This block gives a host processor halfword access to a configuration store that keeps three 32-bit dwords for each of 256 channels. The host does not address the store directly. It loads a 16-bit select register with a channel number, a halfword code and a direction bit. It then either collects the fetched halfword from a 16-bit data register, or the block writes the data register's contents into the store. A busy flag in the select register tells the host when the transfer has finished.

The store is a single-port memory with a read latency that is set by a parameter. A second, internal port stands in for the engine that owns the store in normal operation. That port always wins the memory. A pending host transfer waits for it and stays busy while it waits. The host may change only one halfword per channel. A command that is refused still completes, leaves the store untouched and raises a sticky error bit that the host can clear.

Top module: `cfgram_port`

## Requirements
- R1: After reset the select register, the data register and the status register all read 0x0000, and busy is 0.
- R2: The select register (host_addr 0) reads back the channel in bits 7:0, the halfword code in bits 10:8 and the direction in bit 14 (1 = read, 0 = write). Bits 13:11 read 0. Bit 15 is the busy flag, and host writes cannot set it.
- R3: A read command with code c (0..5) for channel n copies into the data register (host_addr 1) the halfword at store index n*6+c. Code 2k selects the low half of dword k and code 2k+1 selects its high half.
- R4: When the internal port is idle, busy reads 1 for exactly ACC_LAT+1 clock cycles after the clock edge that accepts the command.
- R5: A write command with code 100b stores the data register into that channel's low half of dword 2.
- R6: A write command with any code other than 100b leaves the store unchanged. It completes normally and sets the error bit (status bit 0, host_addr 2).
- R7: Codes 110b and 111b are illegal. Either direction leaves the store and the data register unchanged, completes and sets the error bit.
- R8: The error bit stays set until the host writes status with bit 0 equal to 1.
- R9: While busy is 1, host writes to the select register and to the data register have no effect.
- R10: While int_req is 1 the host transfer does not use the memory. If int_req is high on the H clock edges after the command is accepted, busy stays high for H+ACC_LAT+1 cycles.
- R11: An internal access has priority and takes effect immediately. A write is stored on the request edge. Read data appears on int_rdata ACC_LAT cycles after the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register select: 0 select, 1 data, 2 status |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Register read data for host_addr |
| int_req | input | 1 | Internal port request (priority) |
| int_wr | input | 1 | Internal port direction, 1 = write |
| int_chan | input | 8 | Internal port channel |
| int_word | input | 3 | Internal port halfword code |
| int_wdata | input | 16 | Internal port write data |
| int_rdata | output | 16 | Internal port read data, ACC_LAT cycles after request |

## Verification
The bench builds the block with ACC_LAT = 3 rather than the default 2, so that an off-by-one in the busy window or in the capture cycle changes the counted cycles and the data seen. It uses channels 0 and 255 to reach both ends of the index arithmetic. It preloads the store through the internal port and reads it back the same way, so every protected or illegal host write can be shown to have left the store intact. Holding int_req across the start of a host command exercises the wait path and its longer busy window.

// File: rtl/cfgram_pkg.sv
package cfgram_pkg;

    localparam int NUM_CH     = 256;
    localparam int CHAN_W     = 8;
    localparam int HW_PER_CH  = 6;
    localparam int RAM_DEPTH  = NUM_CH * HW_PER_CH;
    localparam int RAM_AW     = $clog2(RAM_DEPTH);

    localparam logic [1:0] ADDR_SEL  = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam logic [2:0] WSEL_HOST_WR = 3'b100;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_REQ,
        SQ_RUN
    } seq_state_e;

    typedef struct packed {
        logic              rd_cmd;
        logic [2:0]        word;
        logic [CHAN_W-1:0] chan;
    } sel_reg_t;

    function automatic logic word_legal(input logic [2:0] w);
        return int'(w) < HW_PER_CH;
    endfunction

    function automatic logic [RAM_AW-1:0] hw_index(input logic [CHAN_W-1:0] c,
                                                   input logic [2:0] w);
        return RAM_AW'(int'(c) * HW_PER_CH + int'(w));
    endfunction

endpackage

// File: rtl/cfgram_mem.sv
module cfgram_mem #(
    parameter int LAT   = 2,
    parameter int DEPTH = 1536,
    parameter int AW    = 11,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] pipe [LAT];

    always_ff @(posedge clk) begin
        if (req && we) begin
            mem[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe[0] <= '0;
        end else if (req && !we) begin
            pipe[0] <= mem[addr];
        end
    end

    for (genvar s = 1; s < LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe[s] <= '0;
            end else begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign rdata = pipe[LAT-1];

endmodule

// File: rtl/cfgram_seq.sv
module cfgram_seq
    import cfgram_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic hold,
    output logic busy,
    output logic issue,
    output logic done
);

    localparam int CW = $clog2(LAT + 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;

    assign busy  = (state != SQ_IDLE);
    assign issue = (state == SQ_REQ) && !hold;
    assign done  = (state == SQ_RUN) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: if (start) state <= SQ_REQ;
                SQ_REQ: begin
                    if (!hold) begin
                        state <= SQ_RUN;
                        cnt   <= CW'(LAT - 1);
                    end
                end
                SQ_RUN: begin
                    if (cnt == '0) state <= SQ_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfgram_port.sv
module cfgram_port
    import cfgram_pkg::*;
#(
    parameter int ACC_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    input  logic              int_req,
    input  logic              int_wr,
    input  logic [CHAN_W-1:0] int_chan,
    input  logic [2:0]        int_word,
    input  logic [15:0]       int_wdata,
    output logic [15:0]       int_rdata
);

    sel_reg_t    sel_q;
    logic [15:0] data_q;
    logic        err_q;

    logic busy, host_issue, done;
    logic start, data_wr, err_clr;
    logic word_ok, host_may_write, bad_cmd, host_ram_we;

    logic              ram_req, ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic [15:0]       ram_wdata, ram_rdata;

    assign start   = host_wr && (host_addr == ADDR_SEL)  && !busy;
    assign data_wr = host_wr && (host_addr == ADDR_DATA) && !busy;
    assign err_clr = host_wr && (host_addr == ADDR_STAT) && host_wdata[0];

    assign word_ok        = word_legal(sel_q.word);
    assign host_may_write = (sel_q.word == WSEL_HOST_WR);
    assign bad_cmd        = !word_ok || (!sel_q.rd_cmd && !host_may_write);
    assign host_ram_we    = host_issue && !sel_q.rd_cmd && host_may_write;

    cfgram_seq #(.LAT(ACC_LAT)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .hold  (int_req),
        .busy  (busy),
        .issue (host_issue),
        .done  (done)
    );

    always_comb begin
        if (int_req) begin
            ram_req   = 1'b1;
            ram_we    = int_wr;
            ram_addr  = hw_index(int_chan, int_word);
            ram_wdata = int_wdata;
        end else begin
            ram_req   = host_issue;
            ram_we    = host_ram_we;
            ram_addr  = word_ok ? hw_index(sel_q.chan, sel_q.word) : '0;
            ram_wdata = data_q;
        end
    end

    cfgram_mem #(
        .LAT   (ACC_LAT),
        .DEPTH (RAM_DEPTH),
        .AW    (RAM_AW),
        .DW    (16)
    ) u_mem (
        .clk   (clk),
        .rst   (rst),
        .req   (ram_req),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    assign int_rdata = ram_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (start) begin
                sel_q.rd_cmd <= host_wdata[14];
                sel_q.word   <= host_wdata[10:8];
                sel_q.chan   <= host_wdata[7:0];
            end
            if (data_wr) begin
                data_q <= host_wdata;
            end else if (done && sel_q.rd_cmd && word_ok) begin
                data_q <= ram_rdata;
            end
            if (done && bad_cmd) begin
                err_q <= 1'b1;
            end else if (err_clr) begin
                err_q <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (host_addr)
            ADDR_SEL:  host_rdata = {busy, sel_q.rd_cmd, 3'b000, sel_q.word, sel_q.chan};
            ADDR_DATA: host_rdata = data_q;
            ADDR_STAT: host_rdata = {15'd0, err_q};
            default:   host_rdata = 16'd0;
        endcase
    end

endmodule

// File: rtl/cfgram_port_chk.sv
module cfgram_port_chk #(
    parameter int LAT = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        int_req,
    input logic        host_issue,
    input logic        host_ram_we,
    input logic [11:0] sel_bits,
    input logic        host_wr,
    input logic [1:0]  host_addr,
    input logic        clr_bit,
    input logic        err
);

    logic [15:0] bcnt;
    logic        contended;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            bcnt      <= '0;
            contended <= 1'b0;
        end else begin
            bcnt      <= bcnt + 1'b1;
            contended <= contended | int_req;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy && !err));

    assert_busy_window_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !contended) |-> (bcnt == 16'(LAT + 1)));

    assert_write_guard_R6: assert property (@(posedge clk) disable iff (rst)
        host_ram_we |-> (sel_bits[10:8] == 3'b100 && !sel_bits[11]));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (err && !(host_wr && host_addr == 2'd2 && clr_bit)) |=> err);

    assert_sel_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && host_wr && host_addr == 2'd0) |=> $stable(sel_bits));

    assert_int_priority_R10: assert property (@(posedge clk) disable iff (rst)
        int_req |-> !host_issue);

endmodule

bind cfgram_port cfgram_port_chk #(.LAT(ACC_LAT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .int_req     (int_req),
    .host_issue  (host_issue),
    .host_ram_we (host_ram_we),
    .sel_bits    (sel_q),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .clr_bit     (host_wdata[0]),
    .err         (err_q)
);

// File: tb/cfgram_port_bench.sv
module cfgram_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata;
    logic        int_req = 1'b0;
    logic        int_wr = 1'b0;
    logic [7:0]  int_chan = 8'd0;
    logic [2:0]  int_word = 3'd0;
    logic [15:0] int_wdata = 16'd0;
    logic [15:0] int_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgram_port #(.ACC_LAT(LAT)) u_cfgram_port (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .int_req(int_req), .int_wr(int_wr), .int_chan(int_chan),
        .int_word(int_word), .int_wdata(int_wdata), .int_rdata(int_rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sel_word(input logic rd, input logic [2:0] w, input logic [7:0] c);
        return {1'b0, rd, 3'b000, w, c};
    endfunction

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic int_store(input logic [7:0] c, input logic [2:0] w, input logic [15:0] d);
        @(negedge clk);
        int_req = 1'b1; int_wr = 1'b1; int_chan = c; int_word = w; int_wdata = d;
        @(negedge clk);
        int_req = 1'b0; int_wr = 1'b0;
    endtask

    task automatic int_fetch(input logic [7:0] c, input logic [2:0] w, output logic [15:0] d);
        @(negedge clk);
        int_req = 1'b1; int_wr = 1'b0; int_chan = c; int_word = w;
        @(negedge clk);
        int_req = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        d = int_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [15:0] v;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            reg_rd(2'd0, v);
            if (!v[15]) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic host_cmd(input logic rd, input logic [2:0] w, input logic [7:0] c, output int n);
        reg_wr(2'd0, sel_word(rd, w, c));
        wait_idle(n);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        reg_rd(2'd0, v); chk("R1 select", v, 16'h0000);
        reg_rd(2'd1, v); chk("R1 data", v, 16'h0000);
        reg_rd(2'd2, v); chk("R1 status", v, 16'h0000);
    endtask

    task automatic t_read;
        logic [15:0] v; int n;
        int_store(8'd0, 3'd0, 16'h1234);
        int_store(8'd255, 3'd5, 16'hA5A5);
        int_store(8'd7, 3'd3, 16'h0F0F);
        host_cmd(1'b1, 3'd0, 8'd0, n);
        chk("R4 busy cycles read", 16'(n), 16'(LAT + 1));
        reg_rd(2'd1, v); chk("R3 ch0 code0", v, 16'h1234);
        host_cmd(1'b1, 3'd5, 8'd255, n);
        reg_rd(2'd1, v); chk("R3 ch255 code5", v, 16'hA5A5);
        reg_rd(2'd0, v); chk("R2 select readback", v, 16'h45FF);
        host_cmd(1'b1, 3'd3, 8'd7, n);
        reg_rd(2'd1, v); chk("R3 ch7 code3", v, 16'h0F0F);
        reg_rd(2'd2, v); chk("R3 no error on legal read", v, 16'h0000);
    endtask

    task automatic t_write;
        logic [15:0] v; int n;
        reg_wr(2'd1, 16'hBEEF);
        host_cmd(1'b0, 3'd4, 8'd9, n);
        chk("R4 busy cycles write", 16'(n), 16'(LAT + 1));
        int_fetch(8'd9, 3'd4, v); chk("R5 R11 stored halfword", v, 16'hBEEF);
        reg_rd(2'd2, v); chk("R5 no error", v, 16'h0000);
        host_cmd(1'b1, 3'd4, 8'd9, n);
        reg_rd(2'd1, v); chk("R5 host readback", v, 16'hBEEF);
    endtask

    task automatic t_protect;
        logic [15:0] v; int n;
        int_store(8'd9, 3'd1, 16'h1111);
        reg_wr(2'd1, 16'h2222);
        host_cmd(1'b0, 3'd1, 8'd9, n);
        chk("R6 protected write completes", 16'(n), 16'(LAT + 1));
        int_fetch(8'd9, 3'd1, v); chk("R6 store unchanged", v, 16'h1111);
        reg_rd(2'd2, v); chk("R6 error set", v, 16'h0001);
        host_cmd(1'b1, 3'd4, 8'd9, n);
        reg_rd(2'd2, v); chk("R8 error sticky", v, 16'h0001);
        reg_wr(2'd2, 16'h0000);
        reg_rd(2'd2, v); chk("R8 write 0 keeps error", v, 16'h0001);
        reg_wr(2'd2, 16'h0001);
        reg_rd(2'd2, v); chk("R8 error cleared", v, 16'h0000);
    endtask

    task automatic t_illegal;
        logic [15:0] v; int n;
        reg_wr(2'd1, 16'hC0DE);
        host_cmd(1'b1, 3'd6, 8'd9, n);
        chk("R7 illegal read completes", 16'(n), 16'(LAT + 1));
        reg_rd(2'd1, v); chk("R7 data unchanged", v, 16'hC0DE);
        reg_rd(2'd2, v); chk("R7 error on read", v, 16'h0001);
        reg_wr(2'd2, 16'h0001);
        int_store(8'd10, 3'd1, 16'h3333);
        int_store(8'd0, 3'd0, 16'h1234);
        host_cmd(1'b0, 3'd7, 8'd9, n);
        int_fetch(8'd10, 3'd1, v); chk("R7 neighbour unchanged", v, 16'h3333);
        int_fetch(8'd0, 3'd0, v); chk("R7 index 0 unchanged", v, 16'h1234);
        reg_rd(2'd2, v); chk("R7 error on write", v, 16'h0001);
        reg_wr(2'd2, 16'h0001);
    endtask

    task automatic t_busy_ignore;
        logic [15:0] v; int n;
        int_store(8'd3, 3'd2, 16'h4444);
        reg_wr(2'd0, sel_word(1'b1, 3'd2, 8'd3));
        reg_wr(2'd0, sel_word(1'b0, 3'd4, 8'd77));
        reg_wr(2'd1, 16'h5555);
        wait_idle(n);
        reg_rd(2'd0, v); chk("R9 select kept", v, 16'h4203);
        reg_rd(2'd1, v); chk("R9 data from read, not host", v, 16'h4444);
    endtask

    task automatic t_priority;
        logic [15:0] v; int n;
        localparam int H = 4;
        int_store(8'd20, 3'd0, 16'h6789);
        @(negedge clk);
        int_req = 1'b1; int_wr = 1'b0; int_chan = 8'd1; int_word = 3'd0;
        host_wr = 1'b1; host_addr = 2'd0; host_wdata = sel_word(1'b1, 3'd0, 8'd20);
        @(negedge clk);
        host_wr = 1'b0;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            reg_rd(2'd0, v);
            if (!v[15]) break;
            n++;
            if (i == H) int_req = 1'b0;
            @(negedge clk);
        end
        int_req = 1'b0;
        chk("R10 busy extended by internal port", 16'(n), 16'(H + LAT + 1));
        reg_rd(2'd1, v); chk("R10 data after wait", v, 16'h6789);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read();
        t_write();
        t_protect();
        t_illegal();
        t_busy_ignore();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule